// File: doc/BRIEF.md
# Interrupt level delivery pipeline

This block carries a peripheral's interrupt priority from its request and enable registers to a CPU's priority-level inputs. It also decides when the CPU acts on that priority. Software sets the pending requests and the enable mask through write strobes. The request register reads back at once. The highest pending and enabled source is encoded as a 3-bit level. That level passes through a clock-delayed pipe of configurable length before it reaches the CPU's level pins.

On the CPU side, a sampler latches the pin level only in cycles that carry a bus access. At an instruction boundary, the take decision uses the level from the last bus access of the instruction just finished, not the live pin. A level that rises during an instruction's trailing internal cycles is therefore taken one instruction later.

Two conditions make the CPU act on the live pin level instead:
- the CPU is in the stopped state;
- the pipe length is set to zero, which also removes the pipe itself.

There is no data stream here, so every pin is a plain control or status signal and no valid/ready handshake applies.

Top module: `irq_delivery_top`

## Requirements
- R1: The encoded level is i+1 for the highest bit i (0..6) that is set in both the request and enable registers. It is 0 when no bit is set in both.
- R2: A request or enable write strobe commits its data at the clock edge that samples it. `req_rd` shows the committed request value in the very next cycle, with no pipe delay.
- R3: With pipe length L (1..15), the pin level follows the encoded level exactly L cycles late. A request write therefore shows on the pin L+1 cycles after its strobe cycle; with the usual setting of 4 this is 5 cycles. A setting above the maximum stage count is clamped to that maximum.
- R4: With pipe length 0, the pin level equals the encoded level in the same cycle. The take decision at a boundary then uses that live level.
- R5: When the decision is not live, the sampled level loads the pin level only at edges where `bus_cyc` is high. Otherwise it holds its value.
- R6: At an instruction boundary (`insn_end` high, not stopped, L≠0), the decision uses the held sampled level. A pin level that rose after the last bus access is not taken at that boundary.
- R7: While `stopped` is high, the decision uses the live pin level in every cycle. `take` asserts in any stopped cycle where that level qualifies.
- R8: `take` asserts only in a boundary cycle or a stopped cycle. It asserts only when the decision level exceeds `cpu_mask` or equals 7. `take_lvl` carries the decision level while `take` is high and 0 otherwise.
- R9: Reset clears the request and enable registers, every pipe stage and the sampled level. The pin, sampled and take outputs therefore all read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request register write strobe |
| req_wdata | input | 7 | Request register write data, bit i = level i+1 |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 7 | Enable register write data, bit i = level i+1 |
| req_rd | output | 7 | Committed request register, undelayed |
| cfg_pipe_len | input | 4 | Pin pipe length in cycles, 0 = live |
| bus_cyc | input | 1 | CPU bus access in this cycle |
| insn_end | input | 1 | CPU instruction boundary in this cycle |
| stopped | input | 1 | CPU is in the stopped state |
| cpu_mask | input | 3 | Current CPU interrupt mask |
| pin_lvl | output | 3 | Delayed level at the CPU priority pins |
| sampled_lvl | output | 3 | Level latched by the CPU sampler |
| take | output | 1 | Take-interrupt decision for this cycle |
| take_lvl | output | 3 | Level being taken, 0 when take is low |

## Verification
The bench counts the exact cycle in which a request write reaches the pins for lengths 0, 4 and 15. A pipe that is off by one stage, or that delays the readback, shows a wrong value at the edge cycle.

It raises a level while no bus access occurs and then signals a boundary. A design that decides on the live pin would take the interrupt one instruction early.

It also probes the following:
- a stopped CPU, where a design that waits for a bus sample would miss the interrupt;
- masks equal to and one below the level;
- level 7 against mask 7, which a plain greater-than compare wrongly blocks;
- reset in the middle of a run.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_SRC = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Highest set bit i gives level i+1; nothing set gives 0.
  function automatic lvl_t prio_enc(input src_vec_t v);
    lvl_t l;
    l = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (v[i]) l = lvl_t'(i + 1);
    end
    return l;
  endfunction

  // Non-maskable top level, otherwise strictly above the mask.
  function automatic logic lvl_qualifies(input lvl_t l, input lvl_t m);
    return (l == '1) || (l > m);
  endfunction
endpackage

// File: rtl/irq_req_regs.sv
`timescale 1ns/1ps
module irq_req_regs
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_wr,
  input  src_vec_t req_wdata,
  input  logic     en_wr,
  input  src_vec_t en_wdata,
  output src_vec_t req_q,
  output src_vec_t en_q,
  output lvl_t     enc_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      if (req_wr) req_q <= req_wdata;
      if (en_wr)  en_q  <= en_wdata;
    end
  end

  assign enc_lvl = prio_enc(req_q & en_q);

  // R2: a strobed write is visible the following cycle
  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> (req_q == $past(req_wdata)));

  // R1: a nonzero level names a pending, enabled source
  p_enc_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_lvl != '0) |-> (req_q[enc_lvl - 1] && en_q[enc_lvl - 1]));

  // R1: no pending, enabled source lies above the encoded level
  p_enc_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (((req_q & en_q) >> enc_lvl) == '0));
endmodule

// File: rtl/irq_pin_pipe.sv
`timescale 1ns/1ps
module irq_pin_pipe
  import irq_pkg::*;
#(
  parameter int MAX_STAGES = 15,
  localparam int CFG_W = $clog2(MAX_STAGES + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_len,
  input  lvl_t             lvl_in,
  output lvl_t             pin_o
);
  generate
    if (MAX_STAGES == 0) begin : g_bypass
      assign pin_o = lvl_in;
    end else begin : g_pipe
      lvl_t             stg_q [1:MAX_STAGES];
      logic [CFG_W-1:0] eff_len;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 1; k <= MAX_STAGES; k++) stg_q[k] <= '0;
        end else begin
          stg_q[1] <= lvl_in;
          for (int k = 2; k <= MAX_STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
      end

      always_comb begin
        eff_len = (int'(cfg_len) > MAX_STAGES) ? CFG_W'(MAX_STAGES) : cfg_len;
        pin_o   = (eff_len == '0) ? lvl_in : stg_q[eff_len];
      end

      // R3: with a steady single stage, the pin trails the encoder by one cycle
      p_one_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_len == CFG_W'(1) && $past(cfg_len) == CFG_W'(1))
          |-> (pin_o == $past(lvl_in)));
    end
  endgenerate
endmodule

// File: rtl/irq_ipl_sampler.sv
`timescale 1ns/1ps
module irq_ipl_sampler
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t pin_lvl,
  input  logic bypass,
  input  logic bus_cyc,
  input  logic insn_end,
  input  logic stopped,
  input  lvl_t cpu_mask,
  output lvl_t samp_q,
  output logic take,
  output lvl_t take_lvl
);
  logic live;
  lvl_t dec_lvl;

  assign live = stopped | bypass;

  always_ff @(posedge clk) begin
    if (!rst_n)               samp_q <= '0;
    else if (live || bus_cyc) samp_q <= pin_lvl;
  end

  always_comb begin
    dec_lvl  = live ? pin_lvl : samp_q;
    take     = (insn_end | stopped) & lvl_qualifies(dec_lvl, cpu_mask);
    take_lvl = take ? dec_lvl : '0;
  end

  // R5: without a bus access the latched level does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cyc && !live) |=> (samp_q == $past(samp_q)));

  // R5: a bus access captures the pin level
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |=> (samp_q == $past(pin_lvl)));

  // R8: take only at a boundary or while stopped
  p_take_when_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (insn_end || stopped));

  // R8: the taken level beats the mask or is the top level
  p_take_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((take_lvl == 3'd7) || (take_lvl > cpu_mask)));
endmodule

// File: rtl/irq_delivery_top.sv
`timescale 1ns/1ps
module irq_delivery_top
  import irq_pkg::*;
#(
  parameter int MAX_STAGES = 15,
  localparam int CFG_W = $clog2(MAX_STAGES + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [6:0]       req_wdata,
  input  logic             en_wr,
  input  logic [6:0]       en_wdata,
  output logic [6:0]       req_rd,
  input  logic [CFG_W-1:0] cfg_pipe_len,
  input  logic             bus_cyc,
  input  logic             insn_end,
  input  logic             stopped,
  input  logic [2:0]       cpu_mask,
  output logic [2:0]       pin_lvl,
  output logic [2:0]       sampled_lvl,
  output logic             take,
  output logic [2:0]       take_lvl
);
  src_vec_t en_q;
  lvl_t     enc_lvl;

  irq_req_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .req_q     (req_rd),
    .en_q      (en_q),
    .enc_lvl   (enc_lvl)
  );

  irq_pin_pipe #(.MAX_STAGES(MAX_STAGES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_len (cfg_pipe_len),
    .lvl_in  (enc_lvl),
    .pin_o   (pin_lvl)
  );

  irq_ipl_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .bypass   (cfg_pipe_len == '0),
    .bus_cyc  (bus_cyc),
    .insn_end (insn_end),
    .stopped  (stopped),
    .cpu_mask (cpu_mask),
    .samp_q   (sampled_lvl),
    .take     (take),
    .take_lvl (take_lvl)
  );

  // R4: a zero-length pipe presents the encoder output directly
  p_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pipe_len == '0) |-> (pin_lvl == enc_lvl));
endmodule

// File: tb/irq_delivery_top_tb.sv
`timescale 1ns/1ps
module irq_delivery_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr = 1'b0, en_wr = 1'b0;
  logic [6:0] req_wdata = '0, en_wdata = '0;
  logic [6:0] req_rd;
  logic [3:0] cfg_pipe_len = 4'd4;
  logic       bus_cyc = 1'b0, insn_end = 1'b0, stopped = 1'b0;
  logic [2:0] cpu_mask = '0;
  logic [2:0] pin_lvl, sampled_lvl, take_lvl;
  logic       take;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_delivery_top u_dut (.*);

  // {request[6:0], enable[6:0], expected level[2:0]}
  localparam logic [16:0] VEC [8] = '{
    {7'h00, 7'h7F, 3'd0}, {7'h01, 7'h7F, 3'd1},
    {7'h7F, 7'h7F, 3'd7}, {7'h7F, 7'h3F, 3'd6},
    {7'h15, 7'h7F, 3'd5}, {7'h15, 7'h0B, 3'd1},
    {7'h48, 7'h08, 3'd4}, {7'h60, 7'h1F, 3'd0}
  };

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_req(input logic [6:0] d);
    req_wr = 1'b1; req_wdata = d;
    step();
    req_wr = 1'b0;
  endtask

  // Level 3 request; pin must change exactly at negedge len+1 after the strobe edge
  task automatic pipe_test(input int len);
    cfg_pipe_len = 4'(len);
    wr_req(7'h00);
    step(20);
    wr_req(7'h04);
    check("R2 undelayed readback", req_rd, 7'h04);
    for (int k = 1; k <= len + 1; k++) begin
      check($sformatf("R3 pin len %0d cycle %0d", len, k), pin_lvl, (k == len + 1) ? 3 : 0);
      if (k <= len) step();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(3);
    rst_n = 1'b1;
    insn_end = 1'b1; #1;
    check("R9 pin after reset", pin_lvl, 0);
    check("R9 sample after reset", sampled_lvl, 0);
    check("R9 readback after reset", req_rd, 0);
    check("R9 no take after reset", take, 0);
    insn_end = 1'b0;
    step();

    // R1 / R2: encoder vectors, observed live on the pin
    cfg_pipe_len = 4'd0;
    foreach (VEC[i]) begin
      req_wr = 1'b1; en_wr = 1'b1;
      req_wdata = VEC[i][16:10]; en_wdata = VEC[i][9:3];
      step();
      req_wr = 1'b0; en_wr = 1'b0;
      check($sformatf("R1 encode vec %0d", i), pin_lvl, VEC[i][2:0]);
      check($sformatf("R2 readback vec %0d", i), req_rd, VEC[i][16:10]);
    end
    en_wr = 1'b1; en_wdata = 7'h7F; step(); en_wr = 1'b0;

    // R3 / R4: pipe length edges
    pipe_test(0);
    pipe_test(15);
    pipe_test(4);

    // R5 / R6: level rose with no bus access since reset
    step(10);
    check("R5 sample held without bus access", sampled_lvl, 0);
    insn_end = 1'b1; #1;
    check("R6 late level not taken at boundary", take, 0);
    insn_end = 1'b0;
    bus_cyc = 1'b1; step(); bus_cyc = 1'b0;
    check("R5 sample loaded on bus access", sampled_lvl, 3);
    insn_end = 1'b1; #1;
    check("R6 taken at next boundary", take, 1);
    check("R6 taken level", take_lvl, 3);
    cpu_mask = 3'd3; #1;
    check("R8 level equal to mask blocked", take, 0);
    check("R8 blocked level reads 0", take_lvl, 0);
    cpu_mask = 3'd2; #1;
    check("R8 level above mask taken", take, 1);
    insn_end = 1'b0; cpu_mask = 3'd0; #1;
    check("R8 no take off boundary", take, 0);

    // R8: level 7 ignores mask 7
    wr_req(7'h40);
    step(6);
    bus_cyc = 1'b1; step(); bus_cyc = 1'b0;
    cpu_mask = 3'd7; insn_end = 1'b1; #1;
    check("R8 level 7 taken at mask 7", take, 1);
    check("R8 level 7 value", take_lvl, 7);
    insn_end = 1'b0; cpu_mask = 3'd0;

    // R7: stopped CPU acts on the live pin
    wr_req(7'h00);
    step(10);
    bus_cyc = 1'b1; step(); bus_cyc = 1'b0;
    stopped = 1'b1;
    wr_req(7'h02);
    step(3); #1;
    check("R7 stopped before pin rises", take, 0);
    step(); #1;
    check("R7 stopped takes live level", take, 1);
    check("R7 stopped level", take_lvl, 2);
    stopped = 1'b0; #1;
    check("R7 no take after leaving stop", take, 0);

    // R4: zero-length pipe, boundary decision uses live level
    cfg_pipe_len = 4'd0;
    wr_req(7'h00);
    wr_req(7'h10);
    insn_end = 1'b1; #1;
    check("R4 live boundary take", take, 1);
    check("R4 live boundary level", take_lvl, 5);
    insn_end = 1'b0;

    // R9: reset in the middle of a run
    cfg_pipe_len = 4'd4;
    wr_req(7'h7F);
    bus_cyc = 1'b1; step(8); bus_cyc = 1'b0;
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    check("R9 pin cleared", pin_lvl, 0);
    check("R9 sample cleared", sampled_lvl, 0);
    check("R9 request cleared", req_rd, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule